// File: doc/BRIEF.md
# Write-Back Cache with Line Maintenance

This block is a direct-mapped, write-back cache of 8-byte lines placed between a CPU-side word port and a downstream memory such as serial flash or PSRAM. Read and write misses allocate a line. A dirty line that is being evicted is written out before the replacement line is fetched. Downstream traffic uses a single request/acknowledge port that moves one whole line per transfer.

A second port receives writes aimed at a maintenance window. The address of each such write selects a line and carries an operation code in its three least significant bits. The available operations are invalidate, clean and pin. Invalidate and clean each come in a by-set/way form and a by-address form. A pinned line becomes cache-resident storage for one address. It always hits and is never written downstream. An access to any other address that maps to a pinned line goes downstream without allocating, so the pin is kept. A maintenance write is not accepted until any writeback it causes has been acknowledged. Any access that follows it therefore sees the updated line state.

Top module: `wb_cache_maint`

## Requirements
- R1: A read miss fetches the line from downstream and returns the addressed word. Word select is word-address bit 0: 0 picks line bits 31:0 and 1 picks bits 63:32. Later accesses to the same line hit with no downstream request.
- R2: A write hit updates only the cached word and issues no downstream request.
- R3: Misses allocate on both reads and writes. A dirty victim is written back to its own line address before the refill read is issued.
- R4: A downstream request keeps its address, direction and write data stable until it is acknowledged.
- R5: The maintenance address is split as follows: bits 2:0 hold the operation code, the next index bits select the line, and the bits above them are the tag. The codes are 0 invalidate set/way, 1 clean set/way, 2 invalidate by address, 3 clean by address and 7 pin. Codes 4, 5 and 6 change nothing and cause no traffic.
- R6: Clean by address writes the line out only when it is valid, its tag matches and it is dirty, and then clears the dirty flag. Otherwise it does nothing.
- R7: Clean set/way writes out the indexed line if it is dirty, whatever its tag. A pinned line is left unchanged.
- R8: Invalidate by address drops a matching line, discarding any dirty data, so the next access misses and returns downstream contents.
- R9: Invalidate set/way drops the indexed line whatever its tag. This includes a pinned line, which then behaves as an ordinary line again.
- R10: Pin first writes back the indexed line if it is dirty, then assigns the line to the given address. Accesses to that address then hit, and writes to it are never sent downstream.
- R11: A read of another address that maps to a pinned line fetches the line downstream without allocating. A write to such an address does a read, merges the word and writes the line back. The pin stays in place.
- R12: Pinning the same line at a different address moves the pin, so the old address no longer hits.
- R13: The maintenance port asserts ready only once a writeback it triggered has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_word_addr | input | ADDR_W-2 | CPU word address |
| cpu_wdata | input | 32 | CPU write word |
| cpu_ready | output | 1 | CPU access completes this cycle |
| cpu_rdata | output | 32 | CPU read word, valid with cpu_ready |
| mnt_valid | input | 1 | Maintenance write request |
| mnt_addr | input | ADDR_W | Maintenance window offset with opcode in bits 2:0 |
| mnt_ready | output | 1 | Maintenance write accepted |
| mem_req | output | 1 | Downstream line request |
| mem_we | output | 1 | Downstream request is a line write |
| mem_addr | output | ADDR_W-3 | Downstream line address |
| mem_wdata | output | 64 | Downstream line write data |
| mem_ack | input | 1 | Downstream request done; read data valid |
| mem_rdata | input | 64 | Downstream line read data |

## Verification
The embedded assertions check four properties on every cycle: downstream requests stay stable until acknowledged, a pinned line is never dirty and never invalid, a refill read is never issued over a dirty line, and a set/way clean always leaves its line clean. Several behaviours can only be shown by the bench scenarios. These are the contents of the data that is written back, the discarding of dirty data on invalidate, the persistence of a pin under conflicting traffic, the move of a pin to a new address, and the absence of any effect from unused opcodes. The bench shows them by counting downstream reads and writes for each operation and by comparing the returned words against a reference memory.

// File: rtl/wb_cache_maint.sv
module wb_cache_maint #(
  parameter int ADDR_W    = 24,
  parameter int NUM_LINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-3:0] cpu_word_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  input  logic              mnt_valid,
  input  logic [ADDR_W-1:0] mnt_addr,
  output logic              mnt_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int WA_W  = ADDR_W - 2;
  localparam int TAG_W = ADDR_W - 3 - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_WB, S_FILL, S_BWB, S_RESP, S_MWB} st_t;

  st_t                  state;
  logic [63:0]          data_q [NUM_LINES];
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [NUM_LINES-1:0] valid_q, dirty_q, pin_q;
  logic [63:0]          buf_q;

  function automatic logic [63:0] put_word(input logic [63:0] line, input logic sel,
                                           input logic [31:0] w);
    return sel ? {w, line[31:0]} : {line[63:32], w};
  endfunction

  wire [IDX_W-1:0] cidx = cpu_word_addr[IDX_W:1];
  wire [TAG_W-1:0] ctag = cpu_word_addr[WA_W-1:IDX_W+1];
  wire             csel = cpu_word_addr[0];
  wire [IDX_W-1:0] midx = mnt_addr[IDX_W+2:3];
  wire [TAG_W-1:0] mtag = mnt_addr[ADDR_W-1:IDX_W+3];
  wire [2:0]       mop  = mnt_addr[2:0];

  wire        chit     = valid_q[cidx] && (tag_q[cidx] == ctag);
  wire        mmatch   = valid_q[midx] && (tag_q[midx] == mtag);
  wire        mneed_wb = dirty_q[midx] && (mop == 3'd1 || mop == 3'd7 || (mop == 3'd3 && mmatch));
  wire [63:0] cline    = (state == S_RESP) ? buf_q : data_q[cidx];
  wire        mfire    = mnt_valid && mnt_ready;

  assign mnt_ready = (state == S_IDLE && mnt_valid && !mneed_wb) || (state == S_MWB && mem_ack);
  assign cpu_ready = (state == S_IDLE && !mnt_valid && cpu_valid && chit) || (state == S_RESP);
  assign cpu_rdata = csel ? cline[63:32] : cline[31:0];
  assign mem_req   = (state == S_WB) || (state == S_FILL) || (state == S_BWB) || (state == S_MWB);
  assign mem_we    = (state == S_WB) || (state == S_BWB) || (state == S_MWB);

  always_comb begin
    case (state)
      S_MWB:   begin mem_addr = {tag_q[midx], midx}; mem_wdata = data_q[midx]; end
      S_WB:    begin mem_addr = {tag_q[cidx], cidx}; mem_wdata = data_q[cidx]; end
      default: begin mem_addr = {ctag, cidx};        mem_wdata = buf_q;        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
      pin_q   <= '0;
      buf_q   <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (mnt_valid) begin
            if (!mnt_ready) state <= S_MWB;
          end else if (cpu_valid) begin
            if (chit) begin
              if (cpu_we) begin
                data_q[cidx]  <= put_word(data_q[cidx], csel, cpu_wdata);
                dirty_q[cidx] <= !pin_q[cidx];
              end
            end else if (!pin_q[cidx] && dirty_q[cidx]) state <= S_WB;
            else state <= S_FILL;
          end
        S_WB:
          if (mem_ack) begin
            dirty_q[cidx] <= 1'b0;
            valid_q[cidx] <= 1'b0;
            state         <= S_FILL;
          end
        S_FILL:
          if (mem_ack) begin
            if (pin_q[cidx]) begin
              buf_q <= cpu_we ? put_word(mem_rdata, csel, cpu_wdata) : mem_rdata;
              state <= cpu_we ? S_BWB : S_RESP;
            end else begin
              data_q[cidx]  <= mem_rdata;
              tag_q[cidx]   <= ctag;
              valid_q[cidx] <= 1'b1;
              dirty_q[cidx] <= 1'b0;
              state         <= S_IDLE;
            end
          end
        S_BWB:  if (mem_ack) state <= S_RESP;
        S_RESP: state <= S_IDLE;
        S_MWB:  if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      if (mfire) begin
        case (mop)
          3'd0: begin
            valid_q[midx] <= 1'b0; dirty_q[midx] <= 1'b0; pin_q[midx] <= 1'b0;
          end
          3'd1: dirty_q[midx] <= 1'b0;
          3'd2: if (mmatch) begin
            valid_q[midx] <= 1'b0; dirty_q[midx] <= 1'b0; pin_q[midx] <= 1'b0;
          end
          3'd3: if (mmatch) dirty_q[midx] <= 1'b0;
          3'd7: begin
            valid_q[midx] <= 1'b1; dirty_q[midx] <= 1'b0; pin_q[midx] <= 1'b1;
            tag_q[midx]   <= mtag;
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_pin_never_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q & dirty_q) == '0);

  a_r9_pin_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q & ~valid_q) == '0);

  a_r3_fill_over_clean: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !dirty_q[cidx]);

  a_r7_sw_clean_done: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_valid && mnt_ready && mop == 3'd1 |=> !dirty_q[$past(midx)]);
endmodule

// File: tb/wb_cache_maint_bench.sv
module wb_cache_maint_bench;
  localparam int AW = 12;
  localparam int NW = 1 << (AW - 2);

  logic          clk = 0, rst_n = 0;
  logic          cpu_valid = 0, cpu_we = 0;
  logic [AW-3:0] cpu_word_addr = '0;
  logic [31:0]   cpu_wdata = '0;
  logic          cpu_ready;
  logic [31:0]   cpu_rdata;
  logic          mnt_valid = 0;
  logic [AW-1:0] mnt_addr = '0;
  logic          mnt_ready;
  logic          mem_req, mem_we;
  logic [AW-4:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic          mem_ack = 0;
  logic [63:0]   mem_rdata = '0;

  always #5 clk = ~clk;

  wb_cache_maint #(.ADDR_W(AW), .NUM_LINES(64)) u_wb_cache_maint (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_word_addr(cpu_word_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mnt_valid(mnt_valid), .mnt_addr(mnt_addr),
    .mnt_ready(mnt_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  function automatic logic [31:0] init_word(input int w);
    return 32'hC0DE_0000 + 32'(w);
  endfunction

  logic [31:0] mem_w [NW];
  int rd_cnt = 0, wr_cnt = 0, lat = 0;
  int tests = 0, fails = 0;

  initial for (int i = 0; i < NW; i++) mem_w[i] = init_word(i);

  always @(posedge clk) begin
    if (!rst_n || mem_ack) begin
      mem_ack <= 1'b0;
      lat     <= 0;
    end else if (mem_req) begin
      if (lat == 2) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem_w[{mem_addr, 1'b0}] <= mem_wdata[31:0];
          mem_w[{mem_addr, 1'b1}] <= mem_wdata[63:32];
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= {mem_w[{mem_addr, 1'b1}], mem_w[{mem_addr, 1'b0}]};
          rd_cnt    <= rd_cnt + 1;
        end
      end else lat <= lat + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready(input bit is_mnt, output logic [31:0] rd);
    int n = 0;
    #1;
    while (!(is_mnt ? mnt_ready : cpu_ready) && n < 2000) begin
      @(negedge clk); #1; n++;
    end
    rd = cpu_rdata;
    if (n >= 2000) check(0, "handshake timeout", 64'(n), 0);
    @(posedge clk); #1;
    cpu_valid = 0;
    mnt_valid = 0;
  endtask

  // kind: 0 read, 1 write, 2 maintenance (addr carries opcode); chk: 0 none, 1 initial word, 2 literal
  localparam int NV = 41;
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, 12'h010, 32'h0,        2'd1, 2'd1, 2'd0},  // R1 refill
    {2'd0, 12'h014, 32'h0,        2'd1, 2'd0, 2'd0},  // R1 hit same line
    {2'd1, 12'h010, 32'h11111111, 2'd0, 2'd0, 2'd0},  // R2 write hit
    {2'd0, 12'h010, 32'h11111111, 2'd2, 2'd0, 2'd0},  // R2
    {2'd0, 12'h210, 32'h0,        2'd1, 2'd1, 2'd1},  // R3 dirty victim out
    {2'd0, 12'h010, 32'h11111111, 2'd2, 2'd1, 2'd0},  // R3 data landed
    {2'd1, 12'h020, 32'h22222222, 2'd0, 2'd1, 2'd0},  // R3 write allocate
    {2'd2, 12'h023, 32'h0,        2'd0, 2'd0, 2'd1},  // R6 clean by address
    {2'd2, 12'h023, 32'h0,        2'd0, 2'd0, 2'd0},  // R6 already clean
    {2'd0, 12'h020, 32'h22222222, 2'd2, 2'd0, 2'd0},  // R6 still resident
    {2'd1, 12'h030, 32'h33333333, 2'd0, 2'd1, 2'd0},
    {2'd2, 12'h233, 32'h0,        2'd0, 2'd0, 2'd0},  // R6 tag mismatch
    {2'd2, 12'h431, 32'h0,        2'd0, 2'd0, 2'd1},  // R7 set/way any tag
    {2'd1, 12'h040, 32'h44444444, 2'd0, 2'd1, 2'd0},
    {2'd2, 12'h042, 32'h0,        2'd0, 2'd0, 2'd0},  // R8 discard dirty
    {2'd0, 12'h040, 32'h0,        2'd1, 2'd1, 2'd0},  // R8 misses, old data
    {2'd1, 12'h048, 32'h55555555, 2'd0, 2'd1, 2'd0},
    {2'd2, 12'h648, 32'h0,        2'd0, 2'd0, 2'd0},  // R9 set/way any tag
    {2'd0, 12'h048, 32'h0,        2'd1, 2'd1, 2'd0},  // R9
    {2'd1, 12'h058, 32'h66666666, 2'd0, 2'd1, 2'd0},
    {2'd2, 12'h05D, 32'h0,        2'd0, 2'd0, 2'd0},  // R5 code 5 inert
    {2'd2, 12'h05C, 32'h0,        2'd0, 2'd0, 2'd0},  // R5 code 4 inert
    {2'd2, 12'h05B, 32'h0,        2'd0, 2'd0, 2'd1},  // R5 line still dirty
    {2'd1, 12'h068, 32'h77777777, 2'd0, 2'd1, 2'd0},
    {2'd2, 12'h86F, 32'h0,        2'd0, 2'd0, 2'd1},  // R10 dirty out first
    {2'd1, 12'h868, 32'hABCD0001, 2'd0, 2'd0, 2'd0},  // R10 pinned hit
    {2'd0, 12'h868, 32'hABCD0001, 2'd2, 2'd0, 2'd0},  // R10
    {2'd0, 12'h068, 32'h77777777, 2'd2, 2'd1, 2'd0},  // R11 bypass read
    {2'd1, 12'h268, 32'h88888888, 2'd0, 2'd1, 2'd1},  // R11 bypass write
    {2'd0, 12'h868, 32'hABCD0001, 2'd2, 2'd0, 2'd0},  // R11 pin kept
    {2'd2, 12'h069, 32'h0,        2'd0, 2'd0, 2'd0},  // R7 pinned untouched
    {2'd2, 12'h86B, 32'h0,        2'd0, 2'd0, 2'd0},  // R10 never written out
    {2'd0, 12'h868, 32'hABCD0001, 2'd2, 2'd0, 2'd0},  // R7
    {2'd0, 12'h268, 32'h88888888, 2'd2, 2'd1, 2'd0},  // R11 merge landed
    {2'd2, 12'hA6F, 32'h0,        2'd0, 2'd0, 2'd0},  // R12 move pin
    {2'd0, 12'h868, 32'h0,        2'd1, 2'd1, 2'd0},  // R12 old address misses
    {2'd1, 12'hA6C, 32'h99999999, 2'd0, 2'd0, 2'd0},  // R12 new address hits
    {2'd2, 12'h068, 32'h0,        2'd0, 2'd0, 2'd0},  // R9 unpin
    {2'd0, 12'hA6C, 32'h0,        2'd1, 2'd1, 2'd0},  // R9 pin data gone
    {2'd1, 12'hA6C, 32'h9A9A9A9A, 2'd0, 2'd0, 2'd0},
    {2'd2, 12'hA6B, 32'h0,        2'd0, 2'd0, 2'd1}   // R9 ordinary line again
  };

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(!mem_req && !cpu_ready && !mnt_ready, "R4 reset idle",
          {61'd0, mem_req, cpu_ready, mnt_ready}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  kind, chk, dr, dw;
      logic [11:0] a;
      logic [31:0] d, exp;
      int          r0, w0;
      {kind, a, d, chk, dr, dw} = VEC[i];
      @(negedge clk);
      r0 = rd_cnt; w0 = wr_cnt;
      if (kind == 2'd2) begin
        mnt_valid = 1; mnt_addr = a;
        wait_ready(1, rd);
      end else begin
        cpu_valid = 1; cpu_we = kind[0]; cpu_word_addr = a[11:2]; cpu_wdata = d;
        wait_ready(0, rd);
      end
      check(rd_cnt - r0 == int'(dr) && wr_cnt - w0 == int'(dw),
            $sformatf("R13 vector %0d traffic", i),
            {32'(rd_cnt - r0), 32'(wr_cnt - w0)}, {32'(dr), 32'(dw)});
      exp = (chk == 2'd1) ? init_word(int'(a[11:2])) : d;
      if (chk != 2'd0)
        check(rd == exp, $sformatf("R1 vector %0d read data", i), 64'(rd), 64'(exp));
    end

    check(mem_w[12'h010 >> 2] == 32'h11111111, "R3 writeback content",
          64'(mem_w[12'h010 >> 2]), 64'h11111111);
    check(mem_w[12'h020 >> 2] == 32'h22222222, "R6 clean content",
          64'(mem_w[12'h020 >> 2]), 64'h22222222);
    check(mem_w[12'h040 >> 2] == init_word(12'h040 >> 2), "R8 discarded not written",
          64'(mem_w[12'h040 >> 2]), 64'(init_word(12'h040 >> 2)));
    check(mem_w[12'h868 >> 2] == init_word(12'h868 >> 2), "R10 pinned data kept off memory",
          64'(mem_w[12'h868 >> 2]), 64'(init_word(12'h868 >> 2)));
    check(mem_w[12'hA6C >> 2] == 32'h9A9A9A9A, "R9 cleaned after unpin",
          64'(mem_w[12'hA6C >> 2]), 64'h9A9A9A9A);
    check(mem_w[12'h26C >> 2] == init_word(12'h26C >> 2), "R11 merge kept other word",
          64'(mem_w[12'h26C >> 2]), 64'(init_word(12'h26C >> 2)));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule